// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a word-wide main-memory port. It holds 2048 lines of four 32-bit words (32 KB with default parameters), each line with a valid flag and a 17-bit tag. A load whose line is present and whose tag matches returns its word in the same cycle. Any other load holds the processor stalled while all four words of the line are read from memory in ascending order, and then installs them together with the tag and valid flag.

Stores are write-through. A store that hits updates the cached word and places an address/data pair in a small posted queue, which drains to memory in the background. The processor carries on unless the queue is full. A store that misses first brings in the whole line, including the old value of the target word. It then completes as a hit, so the other three words of the line never hold data from a different tag. No line fill is issued while posted writes are outstanding, so a fill always sees the newest memory contents.

The processor holds its request, address, write flag and data stable for as long as stall is high. The memory port carries one transfer at a time: a request is held until a one-cycle acknowledge, and read data is valid in the acknowledge cycle.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid: the first access to any address raises `cpu_stall` in the cycle the request is presented.
- R2: A load to a present line with a matching tag returns the word selected by address bits [3:2] on `cpu_rdata` in the same cycle, with `cpu_stall` low.
- R3: A load miss keeps `cpu_stall` high while exactly four memory reads are made, at word offsets 0, 4, 8 and 12 of the line base in that order. After the fourth acknowledge the line is installed and the load completes with the fetched word.
- R4: Every accepted store updates the cached word, so a later load returns it, and produces exactly one memory write with the same word address and data.
- R5: Posted memory writes reach memory in the order the stores were accepted. A store that hits while the queue has a free slot completes with no stall cycle.
- R6: A store that arrives while the write queue is full (4 entries by default) is stalled until a slot frees. The queue never holds more than its depth.
- R7: A store miss fills the whole line before merging the new word. The other three words of the line then read back their memory values, and the target word reads the new value.
- R8: No memory read is issued while the write queue holds an entry, so a fill that follows a posted store returns the stored value.
- R9: An access to the same index with a different tag misses and replaces the line. A later access to the evicted tag misses again.
- R10: Address bits [1:0] do not affect hit detection or word selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when request is high and stall low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle transfer completion |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
The bench targets a posted store followed at once by a miss to the same index and then by a reload of the stored line. A design that fills before draining would read the stale word back. Store misses are checked word by word: a design that wrote the word without filling would return garbage or the old tag's data in the neighbouring words. A slow memory is used to fill the queue, where a design without a full check would silently drop a write or never stall. Random traffic over a few colliding tags and indexes, with varying memory latency, compares every load and the final memory image against a shadow model. A wrong word select, a missed eviction or a reordered write would show up as a data mismatch.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 2;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_DRAIN = 2'd1,
        FS_FILL  = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } post_entry_t;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/dmc_store_array.sv
`timescale 1ns/1ps
module dmc_store_array
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 11,
    parameter int SEL_W   = 2,
    parameter int TAG_W   = 17
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [INDEX_W-1:0]           rd_index,
    input  logic [TAG_W-1:0]             rd_tag,
    output logic                         hit,
    output logic [(1<<SEL_W)-1:0][WORD_W-1:0] rd_line,
    input  logic                         line_we,
    input  logic [(1<<SEL_W)-1:0][WORD_W-1:0] line_data,
    input  logic                         word_we,
    input  logic [SEL_W-1:0]             word_sel,
    input  logic [WORD_W-1:0]            word_data
);
    localparam int LINES = 1 << INDEX_W;
    localparam int WORDS = 1 << SEL_W;

    logic [LINES-1:0]                    valid_q;
    logic [TAG_W-1:0]                    tag_mem  [LINES];
    logic [WORDS-1:0][WORD_W-1:0]        data_mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (line_we) begin
            valid_q[rd_index] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (line_we) begin
            tag_mem[rd_index]  <= rd_tag;
            data_mem[rd_index] <= line_data;
        end else if (word_we) begin
            data_mem[rd_index][word_sel] <= word_data;
        end
    end

    always_comb begin
        hit     = valid_q[rd_index] && (tag_mem[rd_index] == rd_tag);
        rd_line = data_mem[rd_index];
    end

endmodule

// File: rtl/dmc_post_queue.sv
`timescale 1ns/1ps
module dmc_post_queue
    import dmc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  post_entry_t push_entry,
    input  logic        pop,
    output post_entry_t head,
    output logic        empty,
    output logic        full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    post_entry_t      slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    always_comb begin
        head  = slots[rd_ptr];
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
        count = cnt_q;
    end

endmodule

// File: rtl/dmc_refill_ctrl.sv
`timescale 1ns/1ps
module dmc_refill_ctrl
    import dmc_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               miss_req,
    input  logic                               wb_empty,
    input  logic                               mem_ack,
    input  logic [WORD_W-1:0]                  mem_rdata,
    output logic                               fill_active,
    output logic [SEL_W-1:0]                   fill_sel,
    output logic                               line_we,
    output logic [(1<<SEL_W)-1:0][WORD_W-1:0]  fill_line
);
    localparam int WORDS = 1 << SEL_W;
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(WORDS - 1);

    fill_state_e                 state_q, state_d;
    logic [SEL_W-1:0]            sel_q;
    logic [WORDS-1:0][WORD_W-1:0] gather_q;
    logic                        take;

    assign take = (state_q == FS_FILL) && mem_ack;

    always_comb begin
        state_d = state_q;
        case (state_q)
            FS_IDLE:  if (miss_req) state_d = wb_empty ? FS_FILL : FS_DRAIN;
            FS_DRAIN: if (wb_empty) state_d = FS_FILL;
            FS_FILL:  if (take && sel_q == LAST_SEL) state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) sel_q <= (sel_q == LAST_SEL) ? '0 : sel_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) gather_q[sel_q] <= mem_rdata;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_merge
        if (g == WORDS - 1) begin : g_last
            assign fill_line[g] = mem_rdata;
        end else begin : g_prev
            assign fill_line[g] = gather_q[g];
        end
    end

    assign fill_active = (state_q == FS_FILL);
    assign fill_sel    = sel_q;
    assign line_we     = take && (sel_q == LAST_SEL);

endmodule

// File: rtl/dm_wt_cache.sv
`timescale 1ns/1ps
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int INDEX_W  = 11,
    parameter int SEL_W    = 2,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int TAG_W = ADDR_W - INDEX_W - SEL_W - BYTE_W;
    localparam int WORDS = 1 << SEL_W;
    localparam int CNT_W = $clog2(WB_DEPTH + 1);

    logic [TAG_W-1:0]            a_tag;
    logic [INDEX_W-1:0]          a_index;
    logic [SEL_W-1:0]            a_sel;
    logic                        hit;
    logic [WORDS-1:0][WORD_W-1:0] rd_line;
    logic                        line_we;
    logic [WORDS-1:0][WORD_W-1:0] fill_line;
    logic                        fill_active;
    logic [SEL_W-1:0]            fill_sel;
    logic                        store_ok;
    logic                        wb_push, wb_pop, wb_empty, wb_full;
    logic [CNT_W-1:0]            wb_count;
    post_entry_t                 wb_in, wb_head;

    assign a_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_index = cpu_addr[BYTE_W+SEL_W +: INDEX_W];
    assign a_sel   = cpu_addr[BYTE_W +: SEL_W];

    dmc_store_array #(
        .INDEX_W (INDEX_W),
        .SEL_W   (SEL_W),
        .TAG_W   (TAG_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_index  (a_index),
        .rd_tag    (a_tag),
        .hit       (hit),
        .rd_line   (rd_line),
        .line_we   (line_we),
        .line_data (fill_line),
        .word_we   (store_ok),
        .word_sel  (a_sel),
        .word_data (cpu_wdata)
    );

    dmc_refill_ctrl #(
        .SEL_W (SEL_W)
    ) u_refill (
        .clk         (clk),
        .rst         (rst),
        .miss_req    (cpu_req && !hit),
        .wb_empty    (wb_empty),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .fill_active (fill_active),
        .fill_sel    (fill_sel),
        .line_we     (line_we),
        .fill_line   (fill_line)
    );

    assign store_ok = cpu_req && cpu_we && hit && !wb_full;
    assign wb_push  = store_ok;
    assign wb_in    = '{addr: word_addr(cpu_addr), data: cpu_wdata};
    assign wb_pop   = !fill_active && !wb_empty && mem_ack;

    dmc_post_queue #(
        .DEPTH (WB_DEPTH)
    ) u_post (
        .clk        (clk),
        .rst        (rst),
        .push       (wb_push),
        .push_entry (wb_in),
        .pop        (wb_pop),
        .head       (wb_head),
        .empty      (wb_empty),
        .full       (wb_full),
        .count      (wb_count)
    );

    always_comb begin
        if (fill_active) begin
            mem_req   = 1'b1;
            mem_we    = 1'b0;
            mem_addr  = {a_tag, a_index, fill_sel, {BYTE_W{1'b0}}};
            mem_wdata = '0;
        end else begin
            mem_req   = !wb_empty;
            mem_we    = !wb_empty;
            mem_addr  = wb_head.addr;
            mem_wdata = wb_head.data;
        end
    end

    assign cpu_rdata = rd_line[a_sel];
    assign cpu_stall = cpu_req && (!hit || (cpu_we && wb_full));

endmodule

// File: rtl/dm_wt_cache_chk.sv
`timescale 1ns/1ps
module dm_wt_cache_chk #(
    parameter int WB_DEPTH = 4,
    parameter int SEL_W    = 2,
    parameter int CNT_W    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             cpu_stall,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [31:0]      mem_addr,
    input logic             wb_empty,
    input logic [CNT_W-1:0] wb_count,
    input logic             line_we,
    input logic             fill_active
);
    localparam int WORDS = 1 << SEL_W;

    logic [7:0] reads_seen;

    always_ff @(posedge clk) begin
        if (rst || line_we) reads_seen <= '0;
        else if (mem_req && !mem_we && mem_ack) reads_seen <= reads_seen + 1'b1;
    end

    assert_reads_wait_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> wb_empty);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        wb_count <= CNT_W'(WB_DEPTH));

    assert_fill_len_R3: assert property (@(posedge clk) disable iff (rst)
        line_we |-> (mem_ack && reads_seen == 8'(WORDS - 1)));

    assert_fill_stalls_R3: assert property (@(posedge clk) disable iff (rst)
        fill_active |-> cpu_stall);

    assert_store_posted_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |=> !wb_empty);

endmodule

bind dm_wt_cache dm_wt_cache_chk #(
    .WB_DEPTH (WB_DEPTH),
    .SEL_W    (SEL_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_stall   (cpu_stall),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .wb_empty    (wb_empty),
    .wb_count    (wb_count),
    .line_we     (line_we),
    .fill_active (fill_active)
);

// File: tb/dm_wt_cache_tb.sv
`timescale 1ns/1ps
module dm_wt_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    bit done     = 1'b0;

    logic [31:0] bmem   [logic [31:0]];
    logic [31:0] shadow [logic [31:0]];
    logic [31:0] rd_log[$];
    logic [31:0] wr_log[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_wt_cache #(.INDEX_W(11), .SEL_W(2), .WB_DEPTH(QDEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return {17'(tag), 11'(idx), 2'(w), 2'b00};
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        return shadow.exists(k) ? shadow[k] : init_word(k);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: acknowledges after lat waiting cycles
    initial begin
        int wait_c = 0;
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (!rst && mem_req) begin
                if (wait_c >= lat) begin
                    wait_c  = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        bmem[mem_addr] = mem_wdata;
                        wr_log.push_back(mem_addr);
                        wr_log.push_back(mem_wdata);
                    end else begin
                        mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : init_word(mem_addr);
                        rd_log.push_back(mem_addr);
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        stalls = 0;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        if (we) shadow[{a[31:2], 2'b00}] = d;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int st;
        void'($urandom(32'd20240611));
        rst = 1'b1; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: cold access stalls
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = mk(1, 5, 2); #1;
        check("R1 cold stall", 32'(cpu_stall), 32'd1);
        cpu_req = 1'b0;

        // R3: load miss reads the four words in order
        lat = 2;
        rd_log.delete();
        acc(0, mk(1, 5, 2), 0, rd, st);
        check("R3 data", rd, init_word(mk(1, 5, 2)));
        check("R3 read count", 32'(rd_log.size()), 32'd4);
        for (int i = 0; i < 4; i++)
            if (i < rd_log.size()) check("R3 read order", rd_log[i], mk(1, 5, i));
        check("R3 stalled", 32'(st > 0), 32'd1);

        // R2: hits, each word, no stall
        for (int w = 0; w < 4; w++) begin
            acc(0, mk(1, 5, w), 0, rd, st);
            check("R2 hit data", rd, init_word(mk(1, 5, w)));
            check("R2 hit no stall", 32'(st), 32'd0);
        end

        // R10: byte offset ignored
        acc(0, mk(1, 5, 1) | 32'd3, 0, rd, st);
        check("R10 byte offset data", rd, init_word(mk(1, 5, 1)));
        check("R10 byte offset hit", 32'(st), 32'd0);

        // R4: store hit updates cache and posts one write
        wr_log.delete();
        acc(1, mk(1, 5, 3), 32'hCAFE_0001, rd, st);
        check("R4 store hit no stall", 32'(st), 32'd0);
        acc(0, mk(1, 5, 3), 0, rd, st);
        check("R4 read after store", rd, 32'hCAFE_0001);
        idle(20);
        check("R4 one write", 32'(wr_log.size()), 32'd2);
        if (wr_log.size() >= 2) begin
            check("R4 write addr", wr_log[0], mk(1, 5, 3));
            check("R4 write data", wr_log[1], 32'hCAFE_0001);
        end

        // R7: store miss fills then merges
        acc(1, mk(2, 9, 2), 32'hBEEF_0007, rd, st);
        check("R7 store miss stalls", 32'(st > 0), 32'd1);
        for (int w = 0; w < 4; w++) begin
            acc(0, mk(2, 9, w), 0, rd, st);
            check("R7 merged line", rd, (w == 2) ? 32'hBEEF_0007 : init_word(mk(2, 9, w)));
            check("R7 line present", 32'(st), 32'd0);
        end

        // R8 / R9: posted store, then conflicting miss, then reload
        idle(20);
        lat = 12;
        acc(1, mk(1, 5, 0), 32'h0DD5_0A11, rd, st);
        acc(0, mk(3, 5, 0), 0, rd, st);
        check("R9 conflict data", rd, init_word(mk(3, 5, 0)));
        check("R9 conflict misses", 32'(st > 0), 32'd1);
        acc(0, mk(1, 5, 0), 0, rd, st);
        check("R8 fill sees posted store", rd, 32'h0DD5_0A11);
        check("R9 evicted tag misses", 32'(st > 0), 32'd1);

        // R5 / R6: queue ordering and full stall
        lat = 30;
        wr_log.delete();
        for (int i = 0; i < QDEPTH; i++) begin
            acc(1, mk(1, 5, i), 32'h7000_0000 + i, rd, st);
            check("R5 posted no stall", 32'(st), 32'd0);
        end
        acc(1, mk(1, 5, 1), 32'h7000_0099, rd, st);
        check("R6 full stalls", 32'(st > 0), 32'd1);
        lat = 0;
        idle(300);
        check("R5 write count", 32'(wr_log.size()), 32'(2 * (QDEPTH + 1)));
        for (int i = 0; i <= QDEPTH; i++)
            if (2 * i + 1 < wr_log.size())
                check("R5 write order", wr_log[2*i+1],
                      (i == QDEPTH) ? 32'h7000_0099 : 32'h7000_0000 + i);

        // random traffic with colliding tags and indexes
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            bit we;
            a  = mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3))
                 | 32'($urandom_range(0, 3));
            we = ($urandom_range(0, 2) == 0);
            lat = $urandom_range(0, 3);
            if (we) begin
                acc(1, a, $urandom, rd, st);
            end else begin
                logic [31:0] e;
                e = expect_word(a);
                acc(0, a, 0, rd, st);
                check("R2 R3 R9 random load", rd, e);
            end
        end
        lat = 0;
        idle(100);
        foreach (shadow[k])
            check("R4 final memory image", bmem.exists(k) ? bmem[k] : init_word(k), shadow[k]);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule